// File: doc/BRIEF.md
# Read DMA Requester with Completion Checker

This block moves a programmed amount of data from host memory towards the device as a series of memory-read requests, then watches the returning completion data. After a start command it latches a byte start address, a per-request length in doublewords and a request count. It then presents one request per handshake on a valid/ready port. Each request carries a tag that counts up from zero. Its address is the previous address plus the request length in bytes.

Returned data arrives as one doubleword per beat. The block keeps a running total of accepted doublewords and compares every doubleword with a programmed pattern. The data is then discarded. When the total equals count times length, computed at full width, the transfer ends. At that point the block pulses an interrupt request and freezes a cycle counter. The counter measures the time from the first accepted request to the last expected doubleword. Beats that arrive when no transfer is open are flagged as overrun. A start that arrives while the write direction is busy is refused.

The control state machine has three states. S_IDLE waits for an accepted start. S_ISSUE presents requests. S_DRAIN waits for the outstanding data after the last request has been accepted. The transitions are: S_IDLE to S_ISSUE on an accepted start; S_ISSUE to S_DRAIN when the last request is accepted; S_ISSUE or S_DRAIN to S_IDLE when the final expected doubleword is accepted.

Top module: `rd_dma_engine`

## Requirements
- R1: A start pulse is accepted only if all of the following hold: the block is idle, `wr_busy` is low, and both `cfg_count` and `cfg_size` are non-zero. An accepted start raises `busy` one cycle later. Any other start pulse leaves `busy` and `req_valid` low.
- R2: The first request carries `req_addr` equal to the latched `cfg_addr` and `req_len` equal to `cfg_size`. Each later request's address is the previous one plus `cfg_size` times 4 bytes.
- R3: The first request's `req_tag` is 0. Each later request's tag is the previous tag plus one, modulo 2^TAG_W.
- R4: A request that is not accepted keeps `req_valid`, `req_addr` and `req_tag` unchanged. Exactly `cfg_count` requests are accepted per transfer.
- R5: The transfer completes on the beat that brings the running doubleword total to `cfg_count` × `cfg_size`. In the following cycle `done_irq` is high for exactly one cycle and `busy` is low.
- R6: A completion beat whose `cpl_data` differs from the latched pattern sets `err_mismatch`. The flag stays set until the next accepted start clears it.
- R7: A completion beat while no transfer is open sets `err_overrun`. The flag stays set until the next accepted start clears it.
- R8: The accepted start clears `perf_cycles`. After the transfer it equals the number of clock edges after the edge that accepts the first request, up to and including the edge that accepts the final doubleword. It then holds its value.
- R9: Address, length, count and pattern are latched at the accepted start. Changes to the `cfg_*` inputs during a transfer have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start command pulse |
| wr_busy | input | 1 | Write direction active; start is refused while high |
| cfg_addr | input | ADDR_W | Byte start address |
| cfg_size | input | SIZE_W | Doublewords per request |
| cfg_count | input | CNT_W | Number of requests |
| cfg_pattern | input | 32 | Expected completion doubleword |
| req_valid | output | 1 | Request presented |
| req_ready | input | 1 | Request accepted by the link side |
| req_addr | output | ADDR_W | Request byte address |
| req_len | output | SIZE_W | Request length in doublewords |
| req_tag | output | TAG_W | Request tag |
| cpl_valid | input | 1 | One completion doubleword present |
| cpl_data | input | 32 | Completion doubleword |
| busy | output | 1 | Transfer open |
| done_irq | output | 1 | One-cycle interrupt request at completion |
| err_mismatch | output | 1 | Sticky data-mismatch flag |
| err_overrun | output | 1 | Sticky unexpected-completion flag |
| perf_cycles | output | PERF_W | Transfer duration counter |

## Verification
The assertions check the following on every cycle:
- a stalled request holds steady;
- tags and addresses step correctly between accepted requests;
- a start is refused while the write side is busy;
- the running total stays below the target while a transfer is open;
- the interrupt is a single-cycle pulse;
- both error flags are sticky;
- the duration counter holds once it has stopped.

Only the bench scenarios can show the rest:
- the exact addresses and tags against the programmed values, including the tag wrap after 256 requests;
- the total number of requests;
- the exact value of the duration counter under random back-pressure and random completion gaps;
- that a changed configuration during a transfer is ignored;
- that both error flags clear on the next start.

// File: rtl/rdq_pkg.sv
package rdq_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_DRAIN = 2'd2
    } rdq_state_e;

    localparam int DW_BITS = 32;
    typedef logic [DW_BITS-1:0] dword_t;

endpackage

// File: rtl/rdq_req_fsm.sv
module rdq_req_fsm
    import rdq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 11,
    parameter int CNT_W  = 16,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_busy,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              fin,
    input  logic              req_ready,
    output logic              launch,
    output logic              active,
    output logic              first_hs,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [SIZE_W-1:0] req_len,
    output logic [TAG_W-1:0]  req_tag
);

    rdq_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] size_q;
    logic [CNT_W-1:0]  left_q;
    logic [TAG_W-1:0]  tag_q;
    logic              first_q;
    logic [ADDR_W-1:0] step;
    logic              hs;
    logic              last_req;

    assign step     = ADDR_W'({size_q, 2'b00});
    assign hs       = req_valid && req_ready;
    assign last_req = (left_q == CNT_W'(1));
    assign launch   = start && !wr_busy && (state_q == S_IDLE)
                      && (cfg_count != '0) && (cfg_size != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (launch) state_d = S_ISSUE;
            S_ISSUE: begin
                if (fin)                  state_d = S_IDLE;
                else if (hs && last_req)  state_d = S_DRAIN;
            end
            S_DRAIN: if (fin) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= '0;
            left_q  <= '0;
            tag_q   <= '0;
            first_q <= 1'b0;
        end else if (launch) begin
            addr_q  <= cfg_addr;
            size_q  <= cfg_size;
            left_q  <= cfg_count;
            tag_q   <= '0;
            first_q <= 1'b1;
        end else if (hs) begin
            addr_q  <= addr_q + step;
            left_q  <= left_q - CNT_W'(1);
            tag_q   <= tag_q + TAG_W'(1);
            first_q <= 1'b0;
        end
    end

    always_comb begin
        req_valid = (state_q == S_ISSUE);
        active    = (state_q != S_IDLE);
        first_hs  = hs && first_q;
        req_addr  = addr_q;
        req_len   = size_q;
        req_tag   = tag_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !fin) |=> (req_valid && $stable(req_addr) && $stable(req_tag))); // R4
    AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !last_req) |=> (req_tag == $past(req_tag) + TAG_W'(1))); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !last_req) |=> (req_addr == $past(req_addr) + $past(step))); // R2
    AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && state_q == S_IDLE) |=> (state_q == S_IDLE)); // R1

endmodule

// File: rtl/rdq_cpl_check.sv
module rdq_cpl_check
    import rdq_pkg::*;
#(
    parameter int SIZE_W = 11,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              active,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [CNT_W-1:0]  cfg_count,
    input  dword_t            cfg_pattern,
    input  logic              cpl_valid,
    input  dword_t            cpl_data,
    output logic              fin,
    output logic              done_irq,
    output logic              err_mismatch,
    output logic              err_overrun
);

    localparam int TOT_W = SIZE_W + CNT_W;

    logic [TOT_W-1:0] expect_q;
    logic [TOT_W-1:0] total_q;
    logic [TOT_W-1:0] total_inc;
    dword_t           pat_q;
    logic             beat;

    assign beat      = cpl_valid && active;
    assign total_inc = total_q + TOT_W'(1);
    assign fin       = beat && (total_inc == expect_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expect_q     <= '0;
            total_q      <= '0;
            pat_q        <= '0;
            err_mismatch <= 1'b0;
            err_overrun  <= 1'b0;
            done_irq     <= 1'b0;
        end else begin
            done_irq <= fin;
            if (launch) begin
                expect_q     <= TOT_W'(cfg_count) * TOT_W'(cfg_size);
                total_q      <= '0;
                pat_q        <= cfg_pattern;
                err_mismatch <= 1'b0;
                err_overrun  <= 1'b0;
            end else begin
                if (beat) begin
                    total_q <= total_inc;
                    if (cpl_data != pat_q) err_mismatch <= 1'b1;
                end
                if (cpl_valid && !active) err_overrun <= 1'b1;
            end
        end
    end

    AST_TOTAL_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (total_q < expect_q)); // R5
    AST_IRQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq); // R5
    AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_mismatch && !launch) |=> err_mismatch); // R6
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_overrun && !launch) |=> err_overrun); // R7

endmodule

// File: rtl/rdq_perf_cnt.sv
module rdq_perf_cnt #(
    parameter int PERF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              first_hs,
    input  logic              fin,
    output logic [PERF_W-1:0] perf_cycles
);

    logic running_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q   <= 1'b0;
            perf_cycles <= '0;
        end else if (launch) begin
            running_q   <= 1'b0;
            perf_cycles <= '0;
        end else begin
            if (first_hs)  running_q <= 1'b1;
            else if (fin)  running_q <= 1'b0;
            if (running_q) perf_cycles <= perf_cycles + PERF_W'(1);
        end
    end

    AST_PERF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_q && !launch) |=> $stable(perf_cycles)); // R8

endmodule

// File: rtl/rd_dma_engine.sv
module rd_dma_engine
    import rdq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 11,
    parameter int CNT_W  = 16,
    parameter int TAG_W  = 8,
    parameter int PERF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_busy,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [31:0]       cfg_pattern,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [SIZE_W-1:0] req_len,
    output logic [TAG_W-1:0]  req_tag,
    input  logic              cpl_valid,
    input  logic [31:0]       cpl_data,
    output logic              busy,
    output logic              done_irq,
    output logic              err_mismatch,
    output logic              err_overrun,
    output logic [PERF_W-1:0] perf_cycles
);

    logic launch;
    logic active;
    logic first_hs;
    logic fin;

    rdq_req_fsm #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W),
        .CNT_W  (CNT_W),
        .TAG_W  (TAG_W)
    ) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wr_busy   (wr_busy),
        .cfg_addr  (cfg_addr),
        .cfg_size  (cfg_size),
        .cfg_count (cfg_count),
        .fin       (fin),
        .req_ready (req_ready),
        .launch    (launch),
        .active    (active),
        .first_hs  (first_hs),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_tag   (req_tag)
    );

    rdq_cpl_check #(
        .SIZE_W (SIZE_W),
        .CNT_W  (CNT_W)
    ) u_chk (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .active       (active),
        .cfg_size     (cfg_size),
        .cfg_count    (cfg_count),
        .cfg_pattern  (cfg_pattern),
        .cpl_valid    (cpl_valid),
        .cpl_data     (cpl_data),
        .fin          (fin),
        .done_irq     (done_irq),
        .err_mismatch (err_mismatch),
        .err_overrun  (err_overrun)
    );

    rdq_perf_cnt #(
        .PERF_W (PERF_W)
    ) u_perf (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .first_hs    (first_hs),
        .fin         (fin),
        .perf_cycles (perf_cycles)
    );

    assign busy = active;

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid); // R1

endmodule

// File: tb/rd_dma_engine_tb.sv
module rd_dma_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        wr_busy;
    logic [31:0] cfg_addr;
    logic [10:0] cfg_size;
    logic [15:0] cfg_count;
    logic [31:0] cfg_pattern;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [10:0] req_len;
    logic [7:0]  req_tag;
    logic        cpl_valid;
    logic [31:0] cpl_data;
    logic        busy;
    logic        done_irq;
    logic        err_mismatch;
    logic        err_overrun;
    logic [31:0] perf_cycles;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rd_dma_engine u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .wr_busy      (wr_busy),
        .cfg_addr     (cfg_addr),
        .cfg_size     (cfg_size),
        .cfg_count    (cfg_count),
        .cfg_pattern  (cfg_pattern),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .req_tag      (req_tag),
        .cpl_valid    (cpl_valid),
        .cpl_data     (cpl_data),
        .busy         (busy),
        .done_irq     (done_irq),
        .err_mismatch (err_mismatch),
        .err_overrun  (err_overrun),
        .perf_cycles  (perf_cycles)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint exp_perf(input int t_first, input int t_last);
        return longint'(t_last - t_first);
    endfunction

    task automatic run_xfer(input logic [31:0] a, input int s, input int c,
                            input logic [31:0] p, input int bad, input bit scramble);
        int issued  = 0;
        int pending = 0;
        int sent    = 0;
        int total   = s * c;
        int t0      = 0;
        int t1      = 0;
        int guard   = 0;
        logic [31:0] exp_addr = a;
        logic [7:0]  exp_tag  = 8'd0;
        bit req_ok = 1'b1;
        cfg_addr = a; cfg_size = 11'(s); cfg_count = 16'(c); cfg_pattern = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1", "busy after start", busy, 1);
        if (scramble) begin
            cfg_addr = ~a; cfg_size = 11'(s + 1); cfg_count = 16'(c + 3); cfg_pattern = ~p;
        end
        while (sent < total && guard < 50000) begin
            req_ready = ($urandom % 3) != 0;
            cpl_valid = 1'b0;
            if (pending > 0 && ($urandom % 4) != 0) begin
                cpl_valid = 1'b1;
                cpl_data  = (sent == bad) ? (p ^ 32'h1) : p;
                pending--;
                sent++;
                if (sent == total) t1 = cyc + 1;
            end
            if (req_valid && req_ready) begin
                if (req_addr != exp_addr || req_len != 11'(s) || req_tag != exp_tag) begin
                    if (req_ok) begin
                        chk(req_addr == exp_addr, scramble ? "R9" : "R2", "req_addr", req_addr, exp_addr);
                        chk(req_len == 11'(s), "R2", "req_len", req_len, s);
                        chk(req_tag == exp_tag, "R3", "req_tag", req_tag, exp_tag);
                    end
                    req_ok = 1'b0;
                end
                if (issued == 0) t0 = cyc + 1;
                issued++;
                pending  += s;
                exp_addr += 32'(s * 4);
                exp_tag  += 8'd1;
            end
            @(negedge clk);
            guard++;
        end
        cpl_valid = 1'b0;
        chk(guard < 50000, "R5", "transfer finished", guard, 0);
        chk(req_ok, "R2", "request fields all matched", req_ok, 1);
        chk(done_irq == 1'b1, "R5", "done_irq after final beat", done_irq, 1);
        chk(busy == 1'b0, "R5", "busy low at completion", busy, 0);
        @(negedge clk);
        chk(done_irq == 1'b0, "R5", "done_irq one cycle", done_irq, 0);
        chk(issued == c, scramble ? "R9" : "R4", "requests accepted", issued, c);
        chk(req_valid == 1'b0, "R4", "no request after count", req_valid, 0);
        chk(perf_cycles == 32'(exp_perf(t0, t1)), "R8", "perf_cycles", perf_cycles, exp_perf(t0, t1));
        chk(err_mismatch == (bad >= 0), "R6", "err_mismatch", err_mismatch, (bad >= 0));
        chk(err_overrun == 1'b0, "R7", "err_overrun cleared/clean", err_overrun, 0);
        repeat (2) @(negedge clk);
        chk(perf_cycles == 32'(exp_perf(t0, t1)), "R8", "perf_cycles holds", perf_cycles, exp_perf(t0, t1));
    endtask

    task automatic refused_start(input bit wb, input int s, input int c, input string req);
        cfg_addr = 32'h1000; cfg_size = 11'(s); cfg_count = 16'(c); cfg_pattern = 32'h5A5A_0F0F;
        wr_busy = wb; start = 1'b1;
        @(negedge clk);
        start = 1'b0; wr_busy = 1'b0;
        chk(busy == 1'b0, req, "busy after refused start", busy, 0);
        repeat (3) @(negedge clk);
        chk(req_valid == 1'b0 && busy == 1'b0, req, "no request after refused start", req_valid, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst_n = 1'b0; start = 1'b0; wr_busy = 1'b0; req_ready = 1'b0;
        cpl_valid = 1'b0; cpl_data = '0;
        cfg_addr = '0; cfg_size = '0; cfg_count = '0; cfg_pattern = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && req_valid == 0, "R1", "reset idle", busy, 0);
        chk(done_irq == 0 && err_mismatch == 0 && err_overrun == 0, "R5", "reset flags", done_irq, 0);
        chk(perf_cycles == 0, "R8", "reset perf", perf_cycles, 0);

        // R1: refused starts
        refused_start(1'b1, 4, 4, "R1");
        refused_start(1'b0, 4, 0, "R1");
        refused_start(1'b0, 0, 4, "R1");

        // smallest transfer
        run_xfer(32'h0000_2000, 1, 1, 32'hDEAD_BEEF, -1, 1'b0);
        // tag wrap past 255 (R3)
        run_xfer(32'h0010_0000, 1, 260, 32'h1234_5678, -1, 1'b0);
        // random transfers
        for (int i = 0; i < 8; i++) begin
            run_xfer($urandom & 32'hFFFF_FFFC, 1 + ($urandom % 8), 1 + ($urandom % 24),
                     $urandom, -1, 1'b0);
        end
        // R6: mismatch injection, then cleared by a clean transfer
        run_xfer(32'h0000_8000, 4, 5, 32'hA5A5_A5A5, 7, 1'b0);
        run_xfer(32'h0000_9000, 2, 3, 32'h0F0F_F0F0, -1, 1'b0);
        // R9: config changes during transfer ignored
        run_xfer(32'h0004_0000, 3, 6, 32'hCAFE_F00D, -1, 1'b1);
        // R7: overrun beat while idle
        cpl_valid = 1'b1; cpl_data = 32'hCAFE_F00D;
        @(negedge clk);
        cpl_valid = 1'b0;
        chk(err_overrun == 1'b1, "R7", "overrun set", err_overrun, 1);
        repeat (2) @(negedge clk);
        chk(err_overrun == 1'b1, "R7", "overrun sticky", err_overrun, 1);
        chk(busy == 1'b0, "R7", "overrun does not open transfer", busy, 0);
        run_xfer(32'h0000_A000, 2, 2, 32'h1111_2222, -1, 1'b0);

        ended = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule